// File: doc/BRIEF.md
# Prediction-Guided Self-Test Sequencer

When the redundant-CPU comparator flags a divergence, this sequencer takes over with two items of prediction: whether the error is likely soft or hard, and a ranked list of the CPU units most likely to hold the fault. It stalls the CPUs at once. If the prediction says soft, it skips diagnostics and goes straight to recovery. Recovery holds the CPU reset for a fixed number of cycles and then signals the task to restart.

If the prediction says hard, the sequencer runs a self-test of one unit at a time. It takes the units in ranked order, most likely first. Each test uses a one-cycle start pulse and a done pulse that carries a fail bit. A unit that never answers within a timeout window counts as failed. The first failing unit ends the sequence. The block then holds the CPUs stalled in a safe state until reset and reports that unit. If every ranked unit passes, the error is judged soft after all and recovery runs.

Each sequence ends with a one-cycle log record. The record gives the final error type, the faulty unit when there is one, and whether the prediction was right.

Top module: `diag_seq_top`

## Requirements
- R1: After reset, cpuStall, cpuReset, taskRestart, safeHold, testStart and logValid are all 0.
- R2: errValid sampled high while idle raises cpuStall from the next cycle. errValid sampled at any other time has no effect.
- R3: With predHard=0 captured, no testStart is issued. cpuReset rises two cycles after the cycle in which errValid was sampled.
- R4: With predHard=1 captured, units are tested in ranked order. The rank k unit ID sits in predOrder bits [k*UNIT_W +: UNIT_W], rank 0 first. Each test gets a one-cycle testStart with testUnit carrying that ID. The order is the one captured with errValid, even if predOrder changes later.
- R5: A testDone with testFail=1 ends the sequence. safeHold and cpuStall then stay at 1 until reset, and no further testStart is issued.
- R6: If testDone does not arrive within TIMEOUT_CYC cycles after testStart, the unit under test is treated as failed. A done that arrives in the last cycle of the window still counts as that test's result.
- R7: If all NUM_UNITS ranked units pass, recovery starts, and the log reports logHard=0 and logPredOk=0.
- R8: Recovery holds cpuReset for exactly RESET_CYC cycles. In the next cycle cpuStall falls and taskRestart pulses for one cycle.
- R9: Each sequence emits exactly one one-cycle logValid. A soft prediction logs logHard=0 and logPredOk=1. A found fault logs logHard=1, logUnit set to the failing ID, and logPredOk=1.
- R10: testDone outside a running test wait has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| errValid | input | 1 | Divergence detected, prediction valid |
| predHard | input | 1 | Predicted type: 1 hard, 0 soft |
| predOrder | input | NUM_UNITS*UNIT_W | Ranked unit IDs, rank 0 in the low field |
| testDone | input | 1 | Unit self-test finished |
| testFail | input | 1 | Unit self-test found a fault, valid with testDone |
| testStart | output | 1 | One-cycle start of a unit test |
| testUnit | output | UNIT_W | Unit under test |
| cpuStall | output | 1 | Holds the lockstepped CPUs |
| cpuReset | output | 1 | CPU reset during recovery |
| taskRestart | output | 1 | One-cycle restart request after recovery |
| safeHold | output | 1 | Hard fault located, safe state held |
| logValid | output | 1 | Log record valid |
| logHard | output | 1 | Final type: 1 hard |
| logUnit | output | UNIT_W | Faulty unit ID (0 if none) |
| logPredOk | output | 1 | Prediction matched the final type |

## Verification
The hardest case to reach is a test result that arrives in the very last cycle of the timeout window. Here the done pulse and the expiry compete, and the done must win. The bench has a scripted unit responder that waits a chosen number of cycles after each start pulse. It places one pass exactly TIMEOUT_CYC cycles after a start, and it leaves another start unanswered to force the timeout path. Stray done pulses and error pulses arrive during recovery, which shows that they are ignored.

// File: rtl/diag_seq_pkg.sv
package diag_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_DECIDE, S_TEST_START, S_TEST_WAIT, S_HARD_FOUND, S_RECOVER, S_DONE
  } seqState_t;

  typedef struct packed {
    logic capture;
    logic clrIdx;
    logic incIdx;
    logic clrTimer;
    logic clrRst;
    logic latchFault;
    logic emitLog;
    logic markHard;
    logic endRecover;
  } seqStrobe_t;

  typedef struct packed {
    logic predHard;
    logic lastSlot;
    logic timerExpired;
    logic rstLast;
  } seqStatus_t;
endpackage

// File: rtl/diag_seq_ctrl.sv
module diag_seq_ctrl
  import diag_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       errValid,
  input  logic       testDone,
  input  logic       testFail,
  input  seqStatus_t stat,
  output seqStrobe_t stb,
  output logic       testStart,
  output logic       cpuStall,
  output logic       cpuReset,
  output logic       safeHold
);
  seqState_t st, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= S_IDLE;
    else       st <= nxt;
  end

  always_comb begin
    nxt = st;
    stb = '0;
    unique case (st)
      S_IDLE: if (errValid) begin
        nxt = S_DECIDE;
        stb.capture = 1'b1;
      end
      S_DECIDE: begin
        stb.clrIdx = 1'b1;
        if (stat.predHard) nxt = S_TEST_START;
        else begin
          nxt = S_RECOVER;
          stb.clrRst = 1'b1;
          stb.emitLog = 1'b1;
        end
      end
      S_TEST_START: begin
        nxt = S_TEST_WAIT;
        stb.clrTimer = 1'b1;
      end
      S_TEST_WAIT: begin
        if (testDone) begin
          if (testFail) begin
            nxt = S_HARD_FOUND;
            stb.latchFault = 1'b1;
            stb.emitLog = 1'b1;
            stb.markHard = 1'b1;
          end else if (stat.lastSlot) begin
            nxt = S_RECOVER;
            stb.clrRst = 1'b1;
            stb.emitLog = 1'b1;
          end else begin
            nxt = S_TEST_START;
            stb.incIdx = 1'b1;
          end
        end else if (stat.timerExpired) begin
          nxt = S_HARD_FOUND;
          stb.latchFault = 1'b1;
          stb.emitLog = 1'b1;
          stb.markHard = 1'b1;
        end
      end
      S_HARD_FOUND: nxt = S_DONE;
      S_RECOVER: if (stat.rstLast) begin
        nxt = S_IDLE;
        stb.endRecover = 1'b1;
      end
      S_DONE: nxt = S_DONE;
      default: nxt = S_IDLE;
    endcase
  end

  assign testStart = (st == S_TEST_START);
  assign cpuStall  = (st != S_IDLE);
  assign cpuReset  = (st == S_RECOVER);
  assign safeHold  = (st == S_HARD_FOUND) || (st == S_DONE);

  p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    testStart |=> !testStart);
  p_halt_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    safeHold |=> (safeHold && cpuStall && !testStart));
  p_soft_skip_r3: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_DECIDE && !stat.predHard) |=> cpuReset);
  p_busy_ignores_err_r2: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_TEST_WAIT && !testDone && !stat.timerExpired) |=> (st == S_TEST_WAIT));
endmodule

// File: rtl/diag_seq_dp.sv
module diag_seq_dp
  import diag_seq_pkg::*;
#(
  parameter int NUM_UNITS   = 4,
  parameter int UNIT_W      = 3,
  parameter int TIMEOUT_CYC = 16,
  parameter int RESET_CYC   = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        predHard,
  input  logic [NUM_UNITS*UNIT_W-1:0] predOrder,
  input  seqStrobe_t                  stb,
  output seqStatus_t                  stat,
  output logic [UNIT_W-1:0]           testUnit,
  output logic                        taskRestart,
  output logic                        logValid,
  output logic                        logHard,
  output logic [UNIT_W-1:0]           logUnit,
  output logic                        logPredOk
);
  localparam int IDX_W = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1;
  localparam int TMR_W = $clog2(TIMEOUT_CYC + 1);
  localparam int RST_W = $clog2(RESET_CYC + 1);

  logic [UNIT_W-1:0] orderQ [NUM_UNITS];
  logic [IDX_W-1:0]  idx;
  logic [TMR_W-1:0]  timer;
  logic [RST_W-1:0]  rstCnt;
  logic              predHardQ;

  for (genvar k = 0; k < NUM_UNITS; k++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            orderQ[k] <= '0;
      else if (stb.capture) orderQ[k] <= predOrder[k*UNIT_W +: UNIT_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      predHardQ   <= 1'b0;
      idx         <= '0;
      timer       <= '0;
      rstCnt      <= '0;
      taskRestart <= 1'b0;
      logValid    <= 1'b0;
      logHard     <= 1'b0;
      logUnit     <= '0;
      logPredOk   <= 1'b0;
    end else begin
      if (stb.capture) predHardQ <= predHard;
      if (stb.clrIdx)      idx <= '0;
      else if (stb.incIdx) idx <= idx + 1'b1;
      if (stb.clrTimer)                          timer <= '0;
      else if (timer != TMR_W'(TIMEOUT_CYC - 1)) timer <= timer + 1'b1;
      if (stb.clrRst)                          rstCnt <= '0;
      else if (rstCnt != RST_W'(RESET_CYC - 1)) rstCnt <= rstCnt + 1'b1;
      taskRestart <= stb.endRecover;
      logValid    <= stb.emitLog;
      if (stb.emitLog) begin
        logHard   <= stb.markHard;
        logUnit   <= stb.latchFault ? orderQ[idx] : '0;
        logPredOk <= (stb.markHard == predHardQ);
      end
    end
  end

  assign testUnit          = orderQ[idx];
  assign stat.predHard     = predHardQ;
  assign stat.lastSlot     = (idx == IDX_W'(NUM_UNITS - 1));
  assign stat.timerExpired = (timer == TMR_W'(TIMEOUT_CYC - 1));
  assign stat.rstLast      = (rstCnt == RST_W'(RESET_CYC - 1));

  p_log_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    logValid |=> !logValid);
  p_restart_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    taskRestart |=> !taskRestart);
  p_order_held_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.capture && !stb.incIdx && !stb.clrIdx) |=> $stable(testUnit));
endmodule

// File: rtl/diag_seq_top.sv
module diag_seq_top
  import diag_seq_pkg::*;
#(
  parameter int NUM_UNITS   = 4,
  parameter int UNIT_W      = 3,
  parameter int TIMEOUT_CYC = 16,
  parameter int RESET_CYC   = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        errValid,
  input  logic                        predHard,
  input  logic [NUM_UNITS*UNIT_W-1:0] predOrder,
  input  logic                        testDone,
  input  logic                        testFail,
  output logic                        testStart,
  output logic [UNIT_W-1:0]           testUnit,
  output logic                        cpuStall,
  output logic                        cpuReset,
  output logic                        taskRestart,
  output logic                        safeHold,
  output logic                        logValid,
  output logic                        logHard,
  output logic [UNIT_W-1:0]           logUnit,
  output logic                        logPredOk
);
  seqStrobe_t stb;
  seqStatus_t stat;

  diag_seq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .errValid(errValid), .testDone(testDone),
    .testFail(testFail), .stat(stat), .stb(stb), .testStart(testStart),
    .cpuStall(cpuStall), .cpuReset(cpuReset), .safeHold(safeHold)
  );

  diag_seq_dp #(
    .NUM_UNITS(NUM_UNITS), .UNIT_W(UNIT_W),
    .TIMEOUT_CYC(TIMEOUT_CYC), .RESET_CYC(RESET_CYC)
  ) dp_i (
    .clk(clk), .rstN(rstN), .predHard(predHard), .predOrder(predOrder),
    .stb(stb), .stat(stat), .testUnit(testUnit), .taskRestart(taskRestart),
    .logValid(logValid), .logHard(logHard), .logUnit(logUnit), .logPredOk(logPredOk)
  );

  p_reset_stalled_r8: assert property (@(posedge clk) disable iff (!rstN)
    cpuReset |-> cpuStall);
  p_restart_follows_reset_r8: assert property (@(posedge clk) disable iff (!rstN)
    taskRestart |-> ($past(cpuReset) && !cpuStall));
endmodule

// File: tb/diag_seq_tb.sv
module diag_seq_top_tb_top;
  localparam int N = 4, UW = 3, T = 16, R = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic errValid = 0, predHard = 0, testDone = 0, testFail = 0;
  logic [N*UW-1:0] predOrder = '0;
  logic testStart, cpuStall, cpuReset, taskRestart, safeHold;
  logic logValid, logHard, logPredOk;
  logic [UW-1:0] testUnit, logUnit;

  diag_seq_top #(.NUM_UNITS(N), .UNIT_W(UW), .TIMEOUT_CYC(T), .RESET_CYC(R)) dut_i (
    .clk(clk), .rstN(rstN), .errValid(errValid), .predHard(predHard),
    .predOrder(predOrder), .testDone(testDone), .testFail(testFail),
    .testStart(testStart), .testUnit(testUnit), .cpuStall(cpuStall),
    .cpuReset(cpuReset), .taskRestart(taskRestart), .safeHold(safeHold),
    .logValid(logValid), .logHard(logHard), .logUnit(logUnit), .logPredOk(logPredOk)
  );

  always #4 clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  int startCount = 0, resetCycles = 0, logCount = 0;
  int lastLogU = 0; bit lastLogH = 0, lastLogOk = 0;

  // behavioural reference: phase 0 idle,1 decide,2 start,3 wait,4 found,5 halted,6 recover
  int mPhase = 0, mIdx = 0, mTimer = 0, mRcnt = 0;
  bit mPredH = 0, mRestart = 0, mLogV = 0, mLogH = 0, mLogOk = 0;
  int mLogU = 0;
  int mOrder[$];

  task automatic mLog(bit h, int u, bit ok);
    mLogV = 1; mLogH = h; mLogU = u; mLogOk = ok;
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPhase = 0; mIdx = 0; mTimer = 0; mRcnt = 0; mPredH = 0;
      mRestart = 0; mLogV = 0; mLogH = 0; mLogU = 0; mLogOk = 0;
      mOrder = {0, 0, 0, 0};
    end else begin
      mRestart = 0; mLogV = 0;
      case (mPhase)
        0: if (errValid) begin
          mPhase = 1; mPredH = predHard; mOrder = {};
          for (int k = 0; k < N; k++) mOrder.push_back(int'(predOrder[k*UW +: UW]));
        end
        1: begin
          mIdx = 0;
          if (mPredH) mPhase = 2;
          else begin mPhase = 6; mRcnt = 0; mLog(0, 0, 1); end
        end
        2: begin mPhase = 3; mTimer = 0; end
        3: if (testDone) begin
          if (testFail) begin mPhase = 4; mLog(1, mOrder[mIdx], 1); end
          else if (mIdx == N - 1) begin mPhase = 6; mRcnt = 0; mLog(0, 0, 0); end
          else begin mIdx++; mPhase = 2; end
        end else if (mTimer == T - 1) begin mPhase = 4; mLog(1, mOrder[mIdx], 1); end
        else mTimer++;
        4: mPhase = 5;
        5: mPhase = 5;
        6: if (mRcnt == R - 1) begin mPhase = 0; mRestart = 1; end else mRcnt++;
        default: mPhase = 0;
      endcase
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rstN) begin
    chk(cpuStall == (mPhase != 0), "R2 cpuStall", cpuStall, mPhase != 0);
    chk(cpuReset == (mPhase == 6), "R8 cpuReset", cpuReset, mPhase == 6);
    chk(taskRestart == mRestart, "R8 taskRestart", taskRestart, mRestart);
    chk(safeHold == (mPhase == 4 || mPhase == 5), "R5 safeHold", safeHold, mPhase >= 4 && mPhase <= 5);
    chk(testStart == (mPhase == 2), "R4 testStart", testStart, mPhase == 2);
    if (testStart) chk(int'(testUnit) == mOrder[mIdx], "R4 testUnit", testUnit, mOrder[mIdx]);
    chk(logValid == mLogV, "R9 logValid", logValid, mLogV);
    if (logValid && mLogV) begin
      chk(logHard == mLogH, "R9 logHard", logHard, mLogH);
      chk(int'(logUnit) == mLogU, "R9 logUnit", logUnit, mLogU);
      chk(logPredOk == mLogOk, "R9 logPredOk", logPredOk, mLogOk);
    end
    if (testStart) startCount++;
    if (cpuReset) resetCycles++;
    if (logValid) begin logCount++; lastLogU = logUnit; lastLogH = logHard; lastLogOk = logPredOk; end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  int dly[4]; bit fl[4];

  task automatic clearCounts();
    startCount = 0; resetCycles = 0; logCount = 0;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
  endtask

  task automatic doSeq(bit ph, logic [N*UW-1:0] ord, int nResp);
    clearCounts();
    @(negedge clk); errValid = 1; predHard = ph; predOrder = ord;
    @(negedge clk); errValid = 0; predOrder = ~ord;
    for (int k = 0; k < nResp; k++) begin
      int guard = 0;
      while (!testStart && guard < 100) begin @(negedge clk); guard++; end
      if (dly[k] >= 0) begin
        repeat (dly[k]) @(negedge clk);
        testDone = 1; testFail = fl[k];
        @(negedge clk); testDone = 0; testFail = 0;
      end else @(negedge clk);
    end
    repeat (30) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!cpuStall && !cpuReset && !taskRestart && !safeHold && !testStart && !logValid,
        "R1 reset outputs", cpuStall, 0);
    rstN = 1;
    repeat (2) @(negedge clk);

    // R10: stray done while idle has no effect
    testDone = 1; testFail = 1; @(negedge clk); testDone = 0; testFail = 0;
    @(negedge clk);
    chk(!cpuStall && !safeHold, "R10 stray done idle", cpuStall, 0);

    // R3: soft prediction, with stray error and done during recovery (R2, R10)
    clearCounts();
    @(negedge clk); errValid = 1; predHard = 0; predOrder = {3'd1, 3'd2, 3'd3, 3'd4};
    @(negedge clk); errValid = 0;
    chk(cpuStall && !cpuReset, "R2 stall next cycle", cpuStall, 1);
    @(negedge clk);
    chk(cpuReset, "R3 reset two cycles after error", cpuReset, 1);
    errValid = 1; predHard = 1; testDone = 1; testFail = 1;
    @(negedge clk); errValid = 0; testDone = 0; testFail = 0;
    repeat (10) @(negedge clk);
    chk(startCount == 0, "R3 no test start when soft", startCount, 0);
    chk(resetCycles == R, "R8 reset cycle count", resetCycles, R);
    chk(logCount == 1 && !lastLogH && lastLogOk, "R9 soft-predicted log", logCount, 1);
    chk(!cpuStall, "R2 stray error ignored", cpuStall, 0);

    // R5: hard prediction, third ranked unit fails; ranks 2,0,3,1
    dly = '{2, 5, 1, 1}; fl = '{0, 0, 1, 0};
    doSeq(1, {3'd1, 3'd3, 3'd0, 3'd2}, 3);
    chk(startCount == 3, "R5 stops at first failure", startCount, 3);
    chk(lastLogH && lastLogU == 3 && lastLogOk, "R5 fault unit logged", lastLogU, 3);
    chk(safeHold && cpuStall, "R5 safe state held", safeHold, 1);
    doReset();
    @(negedge clk);
    chk(!cpuStall && !safeHold, "R1 reset leaves safe state", cpuStall, 0);

    // R7: all units pass; third answers in last window cycle (R6 boundary)
    dly = '{1, 3, T, 2}; fl = '{0, 0, 0, 0};
    doSeq(1, {3'd4, 3'd3, 3'd2, 3'd1}, 4);
    chk(startCount == 4, "R6 late done still a pass", startCount, 4);
    chk(logCount == 1 && !lastLogH && !lastLogOk, "R7 soft conclusion log", lastLogOk, 0);
    chk(resetCycles == R && !cpuStall, "R7 recovery completed", resetCycles, R);

    // R6: second ranked unit never answers
    dly = '{4, -1, 0, 0}; fl = '{0, 0, 0, 0};
    doSeq(1, {3'd0, 3'd1, 3'd6, 3'd5}, 2);
    chk(lastLogH && lastLogU == 6, "R6 timeout treated as fault", lastLogU, 6);
    chk(startCount == 2 && safeHold, "R6 sequence halted", startCount, 2);
    doReset();
    repeat (3) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule